// File: doc/BRIEF.md
# Flash Storage Host Controller Register Block

This block is the software-visible register file of a serial flash storage host controller. A host reaches it through a plain 32-bit register bus made of a byte address, a write strobe, write data and combinational read data. It holds the fixed capability and version words, an interrupt status word with an enable word, a controller enable bit and the controller status word it drives, two pairs of list base address registers, and a link command register with three argument registers.

Writing the link command register runs a small decoder at once. Link startup marks the device present and both request lists ready. Hibernate enter and hibernate exit each post their own interrupt bit and load the power-mode field. Any other code reports failure. Every command write, valid or not, posts a command-done interrupt and writes a result code into argument register 2. A level interrupt output is high whenever a valid status bit is set together with its enable bit.

Top module: `fhc_host_regs`

## Requirements
- R1: After a synchronous active-low reset, every stored register reads 0 and `irq` is 0. The capability and version words are constants and keep their values through reset.
- R2: With the default parameters (32 transfer slots, 8 task slots), the capability word at 0x00 reads 0x0107021F. Its fields are transfer slots minus 1 in [4:0], ready-to-transfer count 2 in [15:8], task slots minus 1 in [18:16], and 64-bit addressing in bit 24. All other bits are 0. The version word at 0x04 reads 0x00000310.
- R3: `irq` is 1 exactly when (interrupt status at 0x08) AND 0x00000FFF AND (interrupt enable at 0x0C) is non-zero. It follows the registers in the same cycle as a write to either of them or to the command register.
- R4: Writing the interrupt status word at 0x08 clears each bit written as 1 and leaves each bit written as 0. Writing 0x0C stores the full value. The transfer-done word at 0x28 is also write-one-to-clear.
- R5: Writing 1 to bit 0 of 0x10 while it is 0 sets that bit and sets command-ready (bit 3) in the controller status word at 0x14. Writing 0 while it is 1 clears it and zeroes the whole status word. Any other write to 0x10 changes nothing. The status word at 0x14 is not writable.
- R6: Writing 0x16 (link startup) to the command register at 0x40 sets status bits 0, 1 and 2 (device present, transfer list ready, task list ready) and writes 0x00 to argument 2 at 0x48.
- R7: Writing 0x17 (hibernate enter) to 0x40 sets interrupt bit 6. Writing 0x18 (hibernate exit) sets interrupt bit 5. Both load 1 into the power-mode field [10:8] of 0x14 and write 0x00 to argument 2.
- R8: Any other value written to 0x40 writes 0x01 to argument 2. Every write to 0x40 sets interrupt bit 10 (command done). The command register itself reads 0.
- R9: The low base registers at 0x18 and 0x2C keep only bits [31:10] of the written value. The high base registers at 0x1C and 0x30, the transfer run-stop word at 0x24 and the arguments at 0x44, 0x48 and 0x4C keep all 32 bits.
- R10: Writes to 0x20, 0x34, 0x38, 0x3C and 0x50 have no effect, and these addresses read 0.
- R11: A read at a byte address past 0x50, or with address bits [1:0] non-zero, returns 0. A write to such an address changes no register and leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (8) | Byte address of the access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Each write takes effect at the rising edge on which `wr_en` is sampled high. Because `rdata` and `irq` are combinational from the registers, the result of a write is visible during the low phase of that same clock period. Nothing in the block takes more than one edge. The bench drives each access on a falling edge, lets the next rising edge commit it, and samples `rdata` and `irq` shortly after the following falling edge. By then exactly one edge has passed and no further edge can intervene. Its model applies the same one-edge rule, so every expected value is due at that sample point.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  // word index of each register (byte offset / 4)
  localparam int unsigned W_CAPS   = 0;
  localparam int unsigned W_VER    = 1;
  localparam int unsigned W_ISTAT  = 2;
  localparam int unsigned W_IEN    = 3;
  localparam int unsigned W_CEN    = 4;
  localparam int unsigned W_CSTAT  = 5;
  localparam int unsigned W_XBLO   = 6;
  localparam int unsigned W_XBHI   = 7;
  localparam int unsigned W_XDB    = 8;
  localparam int unsigned W_XRUN   = 9;
  localparam int unsigned W_XDONE  = 10;
  localparam int unsigned W_TBLO   = 11;
  localparam int unsigned W_TBHI   = 12;
  localparam int unsigned W_TDB    = 13;
  localparam int unsigned W_TCLR   = 14;
  localparam int unsigned W_TRUN   = 15;
  localparam int unsigned W_CMD    = 16;
  localparam int unsigned W_ARG1   = 17;
  localparam int unsigned W_ARG2   = 18;
  localparam int unsigned W_ARG3   = 19;
  localparam int unsigned W_XCLR   = 20;
  localparam int unsigned NUM_WORDS = 21;

  // interrupt status bit positions
  localparam int unsigned IS_HIB_EXIT  = 5;
  localparam int unsigned IS_HIB_ENTER = 6;
  localparam int unsigned IS_CMD_DONE  = 10;
  localparam logic [31:0] IRQ_VALID_MASK = 32'h0000_0FFF;

  // controller status bit positions
  localparam int unsigned CS_DEV_PRESENT = 0;
  localparam int unsigned CS_XFER_READY  = 1;
  localparam int unsigned CS_TASK_READY  = 2;
  localparam int unsigned CS_CMD_READY   = 3;
  localparam int unsigned CS_PWR_LSB     = 8;
  localparam logic [2:0]  PWR_LOCAL      = 3'd1;

  localparam logic [31:0] BASE_KEEP_MASK = 32'hFFFF_FC00;
  localparam logic [31:0] VERSION_WORD   = 32'h0000_0310;

  typedef enum logic [7:0] {
    LCMD_STARTUP   = 8'h16,
    LCMD_HIB_ENTER = 8'h17,
    LCMD_HIB_EXIT  = 8'h18
  } link_cmd_e;

  localparam logic [31:0] RESULT_OK   = 32'h0000_0000;
  localparam logic [31:0] RESULT_FAIL = 32'h0000_0001;

  function automatic logic [31:0] make_caps(input int xfer_slots, input int task_slots);
    logic [31:0] c;
    c = '0;
    c[4:0]   = 5'(xfer_slots - 1);
    c[15:8]  = 8'd2;
    c[18:16] = 3'(task_slots - 1);
    c[24]    = 1'b1;
    return c;
  endfunction

  function automatic logic irq_pending(input logic [31:0] stat, input logic [31:0] en);
    return |(stat & IRQ_VALID_MASK & en);
  endfunction

  function automatic logic [31:0] clear_ones(input logic [31:0] cur, input logic [31:0] d);
    return cur & ~d;
  endfunction

endpackage

// File: rtl/fhc_link_cmd.sv
module fhc_link_cmd
  import fhc_pkg::*;
(
  input  logic [31:0] code,
  output logic [31:0] cstat_set,
  output logic        pwr_load,
  output logic [31:0] istat_set,
  output logic [31:0] result
);
  always_comb begin
    cstat_set = '0;
    pwr_load  = 1'b0;
    istat_set = '0;
    istat_set[IS_CMD_DONE] = 1'b1;
    result    = RESULT_FAIL;
    if (code[31:8] == 24'd0) begin
      case (code[7:0])
        LCMD_STARTUP: begin
          cstat_set[CS_DEV_PRESENT] = 1'b1;
          cstat_set[CS_XFER_READY]  = 1'b1;
          cstat_set[CS_TASK_READY]  = 1'b1;
          result = RESULT_OK;
        end
        LCMD_HIB_ENTER: begin
          istat_set[IS_HIB_ENTER] = 1'b1;
          pwr_load = 1'b1;
          result = RESULT_OK;
        end
        LCMD_HIB_EXIT: begin
          istat_set[IS_HIB_EXIT] = 1'b1;
          pwr_load = 1'b1;
          result = RESULT_OK;
        end
        default: result = RESULT_FAIL;
      endcase
    end
  end
endmodule

// File: rtl/fhc_irq_gen.sv
module fhc_irq_gen
  import fhc_pkg::*;
(
  input  logic [31:0] stat,
  input  logic [31:0] en,
  output logic        irq
);
  assign irq = irq_pending(stat, en);
endmodule

// File: rtl/fhc_read_mux.sv
module fhc_read_mux #(
  parameter int unsigned NWORDS = 21
) (
  input  logic                   aligned,
  input  int unsigned            wsel,
  input  logic [NWORDS-1:0][31:0] bank,
  output logic [31:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (wsel == i) rdata = bank[i];
      end
    end
  end
endmodule

// File: rtl/fhc_host_regs.sv
module fhc_host_regs
  import fhc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int XFER_SLOTS = 32,
  parameter int TASK_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [31:0] CAPS_WORD = make_caps(XFER_SLOTS, TASK_SLOTS);

  if (XFER_SLOTS < 1 || XFER_SLOTS > 32) begin : g_bad_xfer
    $error("XFER_SLOTS out of range");
  end
  if (TASK_SLOTS < 1 || TASK_SLOTS > 8) begin : g_bad_task
    $error("TASK_SLOTS out of range");
  end

  // stored state
  logic [31:0] istat_q, ien_q, cstat_q;
  logic        cen_q;
  logic [31:0] xblo_q, xbhi_q, xrun_q, xdone_q;
  logic [31:0] tblo_q, tbhi_q;
  logic [31:0] arg1_q, arg2_q, arg3_q;

  // decode, brought out as named events
  logic        aligned;
  int unsigned wsel;
  logic        in_map;
  logic        any_wr, istat_wr, cmd_wr, cen_wr, cen_rise, cen_fall, stray_wr;

  assign aligned  = (addr[1:0] == 2'b00);
  assign wsel     = int'(addr[ADDR_W-1:2]);
  assign in_map   = aligned && (wsel < NUM_WORDS);
  assign any_wr   = wr_en && in_map;
  assign istat_wr = any_wr && (wsel == W_ISTAT);
  assign cmd_wr   = any_wr && (wsel == W_CMD);
  assign cen_wr   = any_wr && (wsel == W_CEN);
  assign cen_rise = cen_wr && !cen_q && wdata[0];
  assign cen_fall = cen_wr && cen_q && !wdata[0];
  assign stray_wr = wr_en && !in_map;

  // link command decoder
  logic [31:0] lc_cstat_set, lc_istat_set, lc_result;
  logic        lc_pwr_load;

  fhc_link_cmd u_link_cmd (
    .code      (wdata),
    .cstat_set (lc_cstat_set),
    .pwr_load  (lc_pwr_load),
    .istat_set (lc_istat_set),
    .result    (lc_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      istat_q <= '0;
      ien_q   <= '0;
      cstat_q <= '0;
      cen_q   <= 1'b0;
      xblo_q  <= '0;
      xbhi_q  <= '0;
      xrun_q  <= '0;
      xdone_q <= '0;
      tblo_q  <= '0;
      tbhi_q  <= '0;
      arg1_q  <= '0;
      arg2_q  <= '0;
      arg3_q  <= '0;
    end else if (any_wr) begin
      case (wsel)
        W_ISTAT: istat_q <= clear_ones(istat_q, wdata);
        W_IEN:   ien_q   <= wdata;
        W_CEN: begin
          if (cen_rise) begin
            cen_q <= 1'b1;
            cstat_q[CS_CMD_READY] <= 1'b1;
          end else if (cen_fall) begin
            cen_q   <= 1'b0;
            cstat_q <= '0;
          end
        end
        W_XBLO:  xblo_q  <= wdata & BASE_KEEP_MASK;
        W_XBHI:  xbhi_q  <= wdata;
        W_XRUN:  xrun_q  <= wdata;
        W_XDONE: xdone_q <= clear_ones(xdone_q, wdata);
        W_TBLO:  tblo_q  <= wdata & BASE_KEEP_MASK;
        W_TBHI:  tbhi_q  <= wdata;
        W_CMD: begin
          istat_q <= istat_q | lc_istat_set;
          if (lc_pwr_load)
            cstat_q <= (cstat_q | lc_cstat_set) & ~(32'h7 << CS_PWR_LSB)
                       | ({29'd0, PWR_LOCAL} << CS_PWR_LSB);
          else
            cstat_q <= cstat_q | lc_cstat_set;
          arg2_q <= lc_result;
        end
        W_ARG1:  arg1_q <= wdata;
        W_ARG2:  arg2_q <= wdata;
        W_ARG3:  arg3_q <= wdata;
        default: ; // doorbells, clears, task run-stop: accepted, no effect
      endcase
    end
  end

  // read bank
  logic [NUM_WORDS-1:0][31:0] bank;
  always_comb begin
    bank          = '0;
    bank[W_CAPS]  = CAPS_WORD;
    bank[W_VER]   = VERSION_WORD;
    bank[W_ISTAT] = istat_q;
    bank[W_IEN]   = ien_q;
    bank[W_CEN]   = {31'd0, cen_q};
    bank[W_CSTAT] = cstat_q;
    bank[W_XBLO]  = xblo_q;
    bank[W_XBHI]  = xbhi_q;
    bank[W_XRUN]  = xrun_q;
    bank[W_XDONE] = xdone_q;
    bank[W_TBLO]  = tblo_q;
    bank[W_TBHI]  = tbhi_q;
    bank[W_ARG1]  = arg1_q;
    bank[W_ARG2]  = arg2_q;
    bank[W_ARG3]  = arg3_q;
  end

  fhc_read_mux #(.NWORDS(NUM_WORDS)) u_read_mux (
    .aligned (aligned),
    .wsel    (wsel),
    .bank    (bank),
    .rdata   (rdata)
  );

  fhc_irq_gen u_irq_gen (
    .stat (istat_q),
    .en   (ien_q),
    .irq  (irq)
  );

endmodule

// File: rtl/fhc_host_regs_chk.sv
module fhc_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] wdata,
  input logic        irq,
  input logic        istat_wr,
  input logic        cmd_wr,
  input logic        cen_rise,
  input logic        cen_fall,
  input logic        stray_wr,
  input logic [31:0] istat_q,
  input logic [31:0] ien_q,
  input logic [31:0] cstat_q,
  input logic [31:0] arg2_q,
  input logic        cen_q
);
  // R8: every command write posts command-done
  assert_cmd_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> istat_q[10]);

  // R8: result is success or failure only
  assert_result_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (arg2_q == 32'd0 || arg2_q == 32'd1));

  // R4: bits written as 1 to the status word are cleared
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    istat_wr |=> ((istat_q & $past(wdata)) == 32'd0));

  // R5: enable rising edge sets command-ready
  assert_enable_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cen_rise |=> (cen_q && cstat_q[3]));

  // R5: enable falling edge empties controller status
  assert_enable_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cen_fall |=> (!cen_q && cstat_q == 32'd0));

  // R3: no request without some enabled bit
  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != 32'd0 && istat_q != 32'd0));

  // R11: stray writes change nothing
  assert_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> ($stable(istat_q) && $stable(ien_q) && $stable(cstat_q)
                  && $stable(arg2_q) && $stable(irq)));
endmodule

bind fhc_host_regs fhc_host_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wdata    (wdata),
  .irq      (irq),
  .istat_wr (istat_wr),
  .cmd_wr   (cmd_wr),
  .cen_rise (cen_rise),
  .cen_fall (cen_fall),
  .stray_wr (stray_wr),
  .istat_q  (istat_q),
  .ien_q    (ien_q),
  .cstat_q  (cstat_q),
  .arg2_q   (arg2_q),
  .cen_q    (cen_q)
);

// File: tb/fhc_host_regs_test.sv
module fhc_host_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  fhc_host_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // bench model, built from the requirements
  logic [31:0] m_is, m_ie, m_cs, m_xlo, m_xhi, m_xrun, m_xdone, m_tlo, m_thi, m_a1, m_a2, m_a3;
  logic        m_en;

  function automatic void m_reset();
    m_is = 0; m_ie = 0; m_cs = 0; m_en = 0; m_xlo = 0; m_xhi = 0; m_xrun = 0;
    m_xdone = 0; m_tlo = 0; m_thi = 0; m_a1 = 0; m_a2 = 0; m_a3 = 0;
  endfunction

  function automatic void m_write(logic [7:0] a, logic [31:0] d);
    if (a[1:0] != 0 || a > 8'h50) return;
    case (a)
      8'h08: m_is = m_is & ~d;
      8'h0C: m_ie = d;
      8'h10: begin
        if (!m_en && d[0]) begin m_en = 1; m_cs = m_cs | 32'h8; end
        else if (m_en && !d[0]) begin m_en = 0; m_cs = 0; end
      end
      8'h18: m_xlo = {d[31:10], 10'd0};
      8'h1C: m_xhi = d;
      8'h24: m_xrun = d;
      8'h28: m_xdone = m_xdone & ~d;
      8'h2C: m_tlo = {d[31:10], 10'd0};
      8'h30: m_thi = d;
      8'h40: begin
        if (d == 32'h16) begin m_cs = m_cs | 32'h7; m_a2 = 0; end
        else if (d == 32'h17) begin m_is[6] = 1; m_cs[10:8] = 3'd1; m_a2 = 0; end
        else if (d == 32'h18) begin m_is[5] = 1; m_cs[10:8] = 3'd1; m_a2 = 0; end
        else m_a2 = 1;
        m_is[10] = 1;
      end
      8'h44: m_a1 = d;
      8'h48: m_a2 = d;
      8'h4C: m_a3 = d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return {7'd0, 1'b1, 5'd0, 3'd7, 8'd2, 3'd0, 5'd31};
      8'h04: return 32'h310;
      8'h08: return m_is;
      8'h0C: return m_ie;
      8'h10: return {31'd0, m_en};
      8'h14: return m_cs;
      8'h18: return m_xlo;
      8'h1C: return m_xhi;
      8'h24: return m_xrun;
      8'h28: return m_xdone;
      8'h2C: return m_tlo;
      8'h30: return m_thi;
      8'h44: return m_a1;
      8'h48: return m_a2;
      8'h4C: return m_a3;
      default: return 0;
    endcase
  endfunction

  function automatic logic m_irq();
    return |(m_is & 32'hFFF & m_ie);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
  endtask

  task automatic chk_rd(input logic [7:0] a, input string req);
    logic [31:0] exp;
    addr = a;
    #1;
    exp = m_read(a);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req);
    total++;
    if (irq !== m_irq()) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, m_irq());
    end
  endtask

  task automatic chk_val(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 8; a <= 8'h50; a += 4) chk_rd(8'(a), "R1");
    chk_irq("R1");
    // R2: constants
    chk_rd(8'h00, "R2");
    chk_val(rdata, 32'h0107021F, "R2 caps literal");
    chk_rd(8'h04, "R2");

    // R5: enable edges
    wr(8'h10, 32'h1); chk_rd(8'h14, "R5"); chk_val(rdata, 32'h8, "R5 rise");
    wr(8'h10, 32'h3); chk_rd(8'h14, "R5"); chk_rd(8'h10, "R5");
    wr(8'h14, 32'hFFFF_FFFF); chk_rd(8'h14, "R5 status read-only");

    // R6: link startup
    wr(8'h48, 32'hDEAD); wr(8'h40, 32'h16);
    chk_rd(8'h14, "R6"); chk_val(rdata, 32'hF, "R6 status");
    chk_rd(8'h48, "R6"); chk_rd(8'h08, "R8");

    // R3: irq follows enable
    chk_irq("R3");
    wr(8'h0C, 32'h400); chk_irq("R3"); chk_val({31'd0, irq}, 32'd1, "R3 raised");
    wr(8'h0C, 32'h1000); chk_irq("R3 masked bit");

    // R7: hibernate
    wr(8'h40, 32'h17); chk_rd(8'h08, "R7"); chk_rd(8'h14, "R7"); chk_rd(8'h48, "R7");
    wr(8'h40, 32'h18); chk_rd(8'h08, "R7"); chk_val(rdata, 32'h460, "R7 bits");

    // R8: unknown codes
    wr(8'h40, 32'h99); chk_rd(8'h48, "R8"); chk_val(rdata, 32'h1, "R8 fail");
    wr(8'h40, 32'h116); chk_rd(8'h48, "R8"); chk_rd(8'h40, "R8 cmd reads 0");

    // R4: W1C
    wr(8'h08, 32'h040); chk_rd(8'h08, "R4");
    wr(8'h08, 32'h0); chk_rd(8'h08, "R4");
    wr(8'h0C, 32'hFFFF_FFFF); chk_irq("R4");
    wr(8'h08, 32'hFFFF_FFFF); chk_rd(8'h08, "R4"); chk_irq("R4");

    // R9: base masks
    wr(8'h18, 32'hFFFF_FFFF); chk_rd(8'h18, "R9"); chk_val(rdata, 32'hFFFF_FC00, "R9 lo");
    wr(8'h2C, 32'h1234_5678); chk_rd(8'h2C, "R9");
    wr(8'h30, 32'hA5A5_5A5A); chk_rd(8'h30, "R9");
    wr(8'h44, 32'h0BAD_F00D); chk_rd(8'h44, "R9");

    // R10: ignored registers
    wr(8'h20, 32'hFFFF_FFFF); chk_rd(8'h20, "R10");
    wr(8'h3C, 32'hFFFF_FFFF); chk_rd(8'h3C, "R10");
    wr(8'h50, 32'hFFFF_FFFF); chk_rd(8'h50, "R10");

    // R11: stray accesses
    wr(8'h41, 32'h16); chk_rd(8'h08, "R11"); chk_irq("R11");
    wr(8'h0D, 32'h0); chk_rd(8'h0C, "R11");
    wr(8'h54, 32'h1); chk_rd(8'h54, "R11"); chk_rd(8'h46, "R11");

    // R1: reset again
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; m_reset();
    chk_rd(8'h14, "R1"); chk_rd(8'h0C, "R1"); chk_rd(8'h00, "R1"); chk_irq("R1");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = 8'(($urandom % 24) * 4);
      if ($urandom % 16 == 0) a = a | 8'($urandom % 4);
      d = $urandom;
      if (a == 8'h40) begin
        case ($urandom % 4)
          0: d = 32'h16; 1: d = 32'h17; 2: d = 32'h18; default: ;
        endcase
      end
      if (a == 8'h08 || a == 8'h10) d = d & ($urandom % 2 ? 32'hFFFF_FFFF : 32'h0000_0F01);
      wr(a, d);
      chk_rd(8'(($urandom % 24) * 4), "R4 R9 random read");
      chk_irq("R3 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule